// File: doc/BRIEF.md
# Brent-Kung Parallel Prefix Adder

This block adds two K-bit unsigned operands and a carry-in in a single combinational pass, producing a K-bit sum and a carry-out. Each bit position first forms a generate term (both operand bits set) and a propagate term (operand bits differ). A Brent-Kung prefix tree then reduces these into group terms that span from bit 0 up to each position, and every carry, including the carry-out, is taken from those group terms and the carry-in.

The tree is built recursively: neighbouring bit pairs are merged, a half-width copy of the same network is applied to the merged pairs, and each remaining even position receives one final merge. The whole structure is elaborated from the width parameter alone, so 8, 16 and 32-bit instances come from the same source. It suits datapaths where a ripple chain is too slow but a dense prefix tree would cost too many operators and wires.

Top module: `bkpa_adder`

## Requirements
- R1: Bit i has generate g_i = a_i AND b_i and propagate p_i = a_i XOR b_i; sum bit i is p_i XOR c_i, so with no carry in and operands of alternating bits (0xAAAA plus 0x5555 at K = 16) the sum is all ones and carry-out is 0.
- R2: The carry into bit i is G[0,i-1] OR (cin AND P[0,i-1]), with c_0 = cin; a carry-in of 1 on an all-propagate pattern travels through every bit.
- R3: Each merge takes the lower span (g_lo, p_lo) and the upper span (g_hi, p_hi) and yields (g_hi OR (g_lo AND p_hi), p_lo AND p_hi); swapping the order gives wrong sums where a low-half generate meets a high-half kill, e.g. 0x00FF + 0x0F0F = 0x100E.
- R4: The group propagate at position i equals the AND of all bit propagates 0..i, and a group never both generates and propagates.
- R5: The carry-out equals G[0,K-1] OR (cin AND P[0,K-1]); it is the bit at weight 2^K of the full result.
- R6: {cout, sum} equals a + b + cin for every input combination.
- R7: K must be a power of two no smaller than 2, checked at elaboration; K = 8, 16 and 32 all build from the same source.
- R8: With all inputs zero, sum and carry-out are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | First operand |
| b | input | K | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | K | Low K bits of a + b + cin |
| cout | output | 1 | Carry out of bit K-1 |

## Verification
The bench targets the long-carry cases: an all-propagate word with a carry-in, all ones plus all ones, and a single carry crossing the top bit, where a network that dropped the carry-in term or a level of the tree would leave the upper bits unchanged. Patterns that pair a generate in the low half with a kill in the high half expose a merge with its operands swapped, which would produce carries that should have died. Random operands at both 16 and 8 bits catch a recursion that misplaces odd and even positions, which shows up as single wrong sum bits in the middle of the word.

// File: rtl/bkpa_pkg.sv
package bkpa_pkg;

   // Group term covering a contiguous span of bit positions
   typedef struct packed {
      logic g;
      logic p;
   } span_t;

   // Merge a lower span with the upper span directly above it.
   // Order matters: the lower span is always the first argument.
   function automatic span_t span_merge(input span_t lo, input span_t hi);
      span_t r;
      r.g = hi.g | (lo.g & hi.p);
      r.p = lo.p & hi.p;
      return r;
   endfunction

   // Operator count and depth of the tree for a given width
   function automatic int tree_ops(input int w);
      int lg;
      lg = $clog2(w);
      return 2 * w - 2 - lg;
   endfunction

   function automatic int tree_depth(input int w);
      return 2 * $clog2(w) - 1;
   endfunction

endpackage

// File: rtl/bkpa_gp_stage.sv
module bkpa_gp_stage #(
   parameter int W = 16
) (
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   output logic [W-1:0] bit_g,
   output logic [W-1:0] bit_p
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bit_g[i] = op_a[i] & op_b[i];
      assign bit_p[i] = op_a[i] ^ op_b[i];
   end

   // R4
   always_comb begin
      for (int i = 0; i < W; i++) begin
         bit_excl_chk: assert (!(bit_g[i] && bit_p[i]))
            else $error("bit %0d both generates and propagates", i);
      end
   end

endmodule

// File: rtl/bkpa_prefix_net.sv
module bkpa_prefix_net
   import bkpa_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] in_g,
   input  logic [W-1:0] in_p,
   output logic [W-1:0] out_g,
   output logic [W-1:0] out_p
);

   localparam int HALF = W / 2;

   if (W == 1) begin : g_leaf
      assign out_g = in_g;
      assign out_p = in_p;
   end else begin : g_rec
      logic [HALF-1:0] pair_g, pair_p;
      logic [HALF-1:0] odd_g, odd_p;

      // Level 1: merge each even position with the odd one above it
      for (genvar j = 0; j < HALF; j++) begin : g_pair
         span_t lo, hi, m;
         assign lo = '{g: in_g[2*j],   p: in_p[2*j]};
         assign hi = '{g: in_g[2*j+1], p: in_p[2*j+1]};
         assign m  = span_merge(lo, hi);
         assign pair_g[j] = m.g;
         assign pair_p[j] = m.p;
      end

      // Half-width network over the merged pairs gives the odd prefixes
      bkpa_prefix_net #(.W(HALF)) u_half (
         .in_g  (pair_g),
         .in_p  (pair_p),
         .out_g (odd_g),
         .out_p (odd_p)
      );

      for (genvar j = 0; j < HALF; j++) begin : g_odd
         assign out_g[2*j+1] = odd_g[j];
         assign out_p[2*j+1] = odd_p[j];
      end

      assign out_g[0] = in_g[0];
      assign out_p[0] = in_p[0];

      // Final level: each remaining even position takes the odd prefix below
      for (genvar j = 1; j < HALF; j++) begin : g_even
         span_t lo, hi, m;
         assign lo = '{g: odd_g[j-1], p: odd_p[j-1]};
         assign hi = '{g: in_g[2*j],  p: in_p[2*j]};
         assign m  = span_merge(lo, hi);
         assign out_g[2*j] = m.g;
         assign out_p[2*j] = m.p;
      end
   end

   // R4
   always_comb begin
      logic run_p;
      run_p = 1'b1;
      for (int i = 0; i < W; i++) begin
         run_p = run_p & in_p[i];
         grp_prop_chk: assert (out_p[i] == run_p)
            else $error("group propagate %0d wrong", i);
      end
   end

   // R4
   always_comb begin
      for (int i = 0; i < W; i++) begin
         grp_excl_chk: assert (!(out_g[i] && out_p[i]))
            else $error("group %0d both generates and propagates", i);
      end
   end

endmodule

// File: rtl/bkpa_carry_sum.sv
module bkpa_carry_sum #(
   parameter int W = 16
) (
   input  logic [W-1:0] grp_g,
   input  logic [W-1:0] grp_p,
   input  logic [W-1:0] bit_p,
   input  logic         c_in,
   output logic [W-1:0] sum_o,
   output logic         c_out
);

   logic [W:0] carry;

   assign carry[0] = c_in;
   for (genvar i = 0; i < W; i++) begin : g_carry
      assign carry[i+1] = grp_g[i] | (c_in & grp_p[i]);
   end

   assign sum_o = bit_p ^ carry[W-1:0];
   assign c_out = carry[W];

   // R2
   always_comb begin
      for (int i = 0; i < W; i++) begin
         carry_step_chk: assert (carry[i+1] == (grp_g[i] | (grp_p[i] & carry[0]))
                                 || (i > 0 && grp_p[i] && carry[i+1] == carry[i]))
            else $error("carry %0d inconsistent", i + 1);
      end
   end

endmodule

// File: rtl/bkpa_adder.sv
module bkpa_adder
   import bkpa_pkg::*;
#(
   parameter int K = 16
) (
   input  logic [K-1:0] a,
   input  logic [K-1:0] b,
   input  logic         cin,
   output logic [K-1:0] sum,
   output logic         cout
);

   localparam int OPS   = tree_ops(K);
   localparam int DEPTH = tree_depth(K);

   // R7
   if (K < 2 || (K & (K - 1)) != 0) begin : g_bad_width
      $error("bkpa_adder: K=%0d must be a power of two >= 2", K);
   end
   if (OPS < 1 || DEPTH < 1) begin : g_bad_tree
      $error("bkpa_adder: degenerate prefix tree");
   end

   logic [K-1:0] bg, bp, gg, gpv;

   bkpa_gp_stage #(.W(K)) u_gp (
      .op_a  (a),
      .op_b  (b),
      .bit_g (bg),
      .bit_p (bp)
   );

   bkpa_prefix_net #(.W(K)) u_tree (
      .in_g  (bg),
      .in_p  (bp),
      .out_g (gg),
      .out_p (gpv)
   );

   bkpa_carry_sum #(.W(K)) u_cs (
      .grp_g (gg),
      .grp_p (gpv),
      .bit_p (bp),
      .c_in  (cin),
      .sum_o (sum),
      .c_out (cout)
   );

   // R6
   always_comb begin
      logic [K:0] ref_sum;
      ref_sum = {1'b0, a} + {1'b0, b} + {{K{1'b0}}, cin};
      full_add_chk: assert ({cout, sum} == ref_sum)
         else $error("adder result mismatch");
   end

   // R5
   always_comb begin
      carry_out_chk: assert (cout == (gg[K-1] | (cin & gpv[K-1])))
         else $error("carry-out does not match top group term");
   end

endmodule

// File: tb/tb_bkpa_adder.sv
module tb_bkpa_adder;

   localparam int K  = 16;
   localparam int K8 = 8;
   localparam int NV = 12;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [K-1:0]  a, b, sum;
   logic          cin, cout;
   logic [K8-1:0] a8, b8, sum8;
   logic          cin8, cout8;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   bkpa_adder #(.K(K)) dut (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
   );

   bkpa_adder #(.K(K8)) dut8 (
      .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8)
   );

   // {a, b, cin, expected {cout,sum}}
   localparam logic [49:0] VEC [NV] = '{
      {16'h0000, 16'h0000, 1'b0, 17'h00000},  // R8 zero
      {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},  // R1 alternating
      {16'hAAAA, 16'h5555, 1'b1, 17'h10000},  // R2 carry-in ripple
      {16'h0000, 16'hFFFF, 1'b1, 17'h10000},  // R2
      {16'hFFFF, 16'h0001, 1'b0, 17'h10000},  // R5
      {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R5 all ones
      {16'h8000, 16'h8000, 1'b0, 17'h10000},  // R5 top bit only
      {16'h00FF, 16'h0F0F, 1'b0, 17'h0100E},  // R3 low generate meets high kill
      {16'h7FFF, 16'h0001, 1'b0, 17'h08000},  // R4 long propagate
      {16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
      {16'hF0F0, 16'h0F10, 1'b0, 17'h10000},  // R3
      {16'h5555, 16'h5555, 1'b1, 17'h0AAAB}   // R6
   };

   task automatic check(input string req, input logic [K:0] got, input logic [K:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      a = '0; b = '0; cin = 1'b0;
      a8 = '0; b8 = '0; cin8 = 1'b0;

      // R8: idle state with all inputs zero
      @(posedge clk); #1;
      check("R8", {cout, sum}, '0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {a, b, cin} = VEC[i][49:17];
         @(posedge clk); #1;
         check($sformatf("R6 vec%0d", i), {cout, sum}, VEC[i][16:0]);
      end

      // R6: random operands at K = 16 against behavioural sum
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         a = K'($urandom); b = K'($urandom); cin = 1'($urandom);
         @(posedge clk); #1;
         check("R6 rand16", {cout, sum}, {1'b0, a} + {1'b0, b} + {{K{1'b0}}, cin});
      end

      // R7: the same source at K = 8, exhaustive over a with fixed patterns of b
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         a8 = 8'(i); b8 = 8'(i * 37 + 11); cin8 = 1'(i >> 3);
         @(posedge clk); #1;
         check("R7 k8", {7'b0, cout8, sum8},
               {8'b0, ({1'b0, a8} + {1'b0, b8} + {8'b0, cin8})});
      end

      // R5: carry-out set by carry-in alone on all-ones at K = 8
      @(negedge clk);
      a8 = 8'hFF; b8 = 8'h00; cin8 = 1'b1;
      @(posedge clk); #1;
      check("R5 k8", {7'b0, cout8, sum8}, 17'h00100);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule